// File: doc/BRIEF.md
# SCSI DMA Handshake Engine

This block moves one byte at a time between a host-side byte stream and the REQ/ACK handshake of a parallel SCSI bus. It works either as the initiator, which answers the target's REQ with ACK, or as the target, which raises REQ and waits for the initiator's ACK. A transfer begins when the host writes to one of three start addresses. Each address selects a direction and a role. The data written is ignored. From then on the engine sequences every bus handshake without help. It raises a DMA request while the host side has work to do, and it stops when the host marks the final byte.

The host side has two valid/ready streams. The send stream carries bytes toward the bus. The engine raises `snd_ready` only when it can take a byte, and a byte moves on any cycle where `snd_valid` and `snd_ready` are both high. The receive stream carries captured bytes back to the host. Once `rcv_valid` is raised, it and `rcv_data` stay fixed until `rcv_ready` is seen. The engine does not answer a new bus request until that byte has been taken. `host_last` is sampled together with a host beat on either stream and marks that beat's byte as the final one.

Status pins report several events, each as a sticky bit that the next accepted start clears: normal completion, completion of the final byte of a send, a bus phase mismatch, and an interrupt. `dreq` is the request pin toward a DMA controller. Its shape depends on whether block mode is selected.

Top module: `scsi_dma_engine`

## Requirements
- R1: With `dma_en` high and the engine idle, a `cmd_wr` pulse starts a transfer for three addresses only. Address 5 starts a send, in the target role when `tgt_mode` is 1 and otherwise as initiator. Address 6 starts a target receive. Address 7 starts an initiator receive. A write to addresses 0 to 4, a write while `dma_en` is low, and a write while busy are all ignored. An accepted start clears `dma_end`, `tx_last_done`, `phase_fault` and `irq`.
- R2: Initiator send. Once a host byte is accepted, the engine drives it on `scsi_db_o` with `scsi_db_oe` high. `scsi_ack_o` rises one cycle after `scsi_req_i` is seen high. `scsi_ack_o` falls one cycle after `scsi_req_i` is seen low.
- R3: Target send. Once a host byte is accepted, the engine drives it and raises `scsi_req_o`. `scsi_req_o` falls one cycle after `scsi_ack_i` is seen high. The byte is complete one cycle after `scsi_ack_i` is seen low.
- R4: Initiator receive. `scsi_ack_o` rises one cycle after `scsi_req_i` is seen high. The stored byte is the value of `scsi_db_i` on the last cycle that REQ was high, which makes it the falling-edge value. One cycle after REQ is seen low, `scsi_ack_o` drops and the byte is offered on the receive stream.
- R5: Target receive. `scsi_req_o` is high while the engine waits. It falls one cycle after `scsi_ack_i` is seen high. The byte stored is the bus value on the last cycle that ACK was high. It is offered on the receive stream one cycle after ACK is seen low.
- R6: When `blk_mode` is 0, `dreq` is high exactly while a host beat is pending. It drops in the cycle after that beat.
- R7: When `blk_mode` is 1, `dreq` is high on every cycle from the accepted start until the transfer ends.
- R8: A byte whose host beat carried `host_last` ends the transfer. This happens after that byte's bus handshake for a send, and at the host beat itself for a receive. In the same cycle `xfer_busy` falls and `dma_end` is set.
- R9: `tx_last_done` is set when the final byte of a send completes its bus handshake. It is never set by a receive.
- R10: A normal end raises `irq` only when `eop_irq_en` is 1.
- R11: In the initiator role, a cycle where `bus_phase` differs from `exp_phase` stops the transfer. `phase_fault` and `irq` are set and `dma_end` is left clear. The target role ignores `bus_phase`.
- R12: Pulling `dma_en` low during a transfer returns the engine to idle on the next cycle. It releases REQ, ACK and the data drivers and leaves every status flag unchanged.
- R13: Back-pressure. While the send stream is stalled, the bus pins are not driven and REQ gets no answer. While a received byte waits, `rcv_valid` and `rcv_data` hold and the next REQ is not acknowledged. A driven byte stays stable for its whole handshake.
- R14: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Register write strobe |
| cmd_addr | input | 3 | Register write address |
| dma_en | input | 1 | DMA enable; low aborts |
| blk_mode | input | 1 | Hold `dreq` for the whole transfer |
| tgt_mode | input | 1 | Role for a send start (1 = target) |
| eop_irq_en | input | 1 | Enable interrupt on normal end |
| exp_phase | input | 3 | Programmed bus phase |
| bus_phase | input | 3 | Observed bus phase lines |
| snd_valid | input | 1 | Send stream byte valid |
| snd_ready | output | 1 | Engine can take a send byte |
| snd_data | input | 8 | Send stream byte |
| host_last | input | 1 | Marks the current host beat as final |
| rcv_valid | output | 1 | Received byte available |
| rcv_ready | input | 1 | Host takes the received byte |
| rcv_data | output | 8 | Received byte |
| dreq | output | 1 | DMA request |
| scsi_req_i | input | 1 | REQ seen on the bus |
| scsi_ack_i | input | 1 | ACK seen on the bus |
| scsi_req_o | output | 1 | REQ driven (target role) |
| scsi_ack_o | output | 1 | ACK driven (initiator role) |
| scsi_db_i | input | 8 | Data lines seen on the bus |
| scsi_db_o | output | 8 | Data lines to drive |
| scsi_db_oe | output | 1 | Data driver enable |
| xfer_busy | output | 1 | Transfer in progress |
| dma_end | output | 1 | Transfer ended normally |
| tx_last_done | output | 1 | Final send byte has left |
| phase_fault | output | 1 | Stopped on phase mismatch |
| irq | output | 1 | Interrupt |

## Verification
A wrong sequencer state shows up at the bus pins within one cycle. A handshake stage that is skipped or repeated makes ACK or REQ move one cycle early or late, or not move at all. A byte captured at the wrong moment appears on `rcv_data` as the value from the wrong bus cycle on the first receive beat. The bench makes this visible by changing the data lines while the strobe is still high, and again as it falls. Flag errors appear on the cycle the transfer ends or is stopped. `dreq` errors appear on the cycle after the first host beat, where the two modes differ.

// File: rtl/sdh_pkg.sv
package sdh_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_FETCH   = 3'd1,
    ST_OFFER   = 3'd2,
    ST_CLOSE   = 3'd3,
    ST_DELIVER = 3'd4
  } sdh_state_e;

  typedef struct packed {
    logic send;
    logic target;
  } sdh_kind_t;

endpackage

// File: rtl/sdh_launch.sv
module sdh_launch
  import sdh_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int SEND_ADDR = 5,
  parameter int TRX_ADDR  = 6,
  parameter int IRX_ADDR  = 7
) (
  input  logic              cmd_wr,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              tgt_mode,
  output logic              go,
  output sdh_kind_t         kind
);

  localparam int NUM_STARTS = 3;
  localparam logic [ADDR_W-1:0] START_ADDR [NUM_STARTS] = '{
    ADDR_W'(SEND_ADDR), ADDR_W'(TRX_ADDR), ADDR_W'(IRX_ADDR)
  };

  logic [NUM_STARTS-1:0] hit;

  for (genvar g = 0; g < NUM_STARTS; g++) begin : g_hit
    assign hit[g] = cmd_wr && (cmd_addr == START_ADDR[g]);
  end

  assign go          = |hit;
  assign kind.send   = hit[0];
  assign kind.target = hit[1] | (hit[0] & tgt_mode);

endmodule

// File: rtl/sdh_sequencer.sv
module sdh_sequencer
  import sdh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  sdh_kind_t  kind,
  input  logic       dma_en,
  input  logic       phase_match,
  input  logic       req_i,
  input  logic       ack_i,
  input  logic       snd_beat,
  input  logic       rcv_beat,
  input  logic       host_last,
  output sdh_state_e state,
  output logic       req_o,
  output logic       ack_o,
  output logic       drive_en,
  output logic       cap_en,
  output logic       evt_start,
  output logic       evt_done,
  output logic       evt_last_sent,
  output logic       evt_mismatch
);

  sdh_state_e nxt;
  sdh_kind_t  kind_q;
  logic       last_q;
  logic       strobe_hi;
  logic       on_bus;

  // The handshake partner's strobe: ACK when we act as target, REQ otherwise.
  assign strobe_hi = kind_q.target ? ack_i : req_i;
  assign on_bus    = (state == ST_OFFER) || (state == ST_CLOSE);

  always_comb begin
    nxt           = state;
    evt_start     = 1'b0;
    evt_done      = 1'b0;
    evt_last_sent = 1'b0;
    evt_mismatch  = 1'b0;
    if (state == ST_IDLE) begin
      if (go && dma_en) begin
        evt_start = 1'b1;
        nxt       = kind.send ? ST_FETCH : ST_OFFER;
      end
    end else if (!dma_en) begin
      nxt = ST_IDLE;
    end else if (!kind_q.target && !phase_match) begin
      nxt          = ST_IDLE;
      evt_mismatch = 1'b1;
    end else begin
      unique case (state)
        ST_FETCH:   if (snd_beat) nxt = ST_OFFER;
        ST_OFFER:   if (strobe_hi) nxt = ST_CLOSE;
        ST_CLOSE: begin
          if (!strobe_hi) begin
            if (!kind_q.send) begin
              nxt = ST_DELIVER;
            end else if (last_q) begin
              nxt           = ST_IDLE;
              evt_done      = 1'b1;
              evt_last_sent = 1'b1;
            end else begin
              nxt = ST_FETCH;
            end
          end
        end
        ST_DELIVER: begin
          if (rcv_beat) begin
            if (host_last) begin
              nxt      = ST_IDLE;
              evt_done = 1'b1;
            end else begin
              nxt = ST_OFFER;
            end
          end
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      kind_q <= '0;
      last_q <= 1'b0;
    end else begin
      state <= nxt;
      if (evt_start) begin
        kind_q <= kind;
        last_q <= 1'b0;
      end else if (snd_beat) begin
        last_q <= host_last;
      end
    end
  end

  assign req_o    = kind_q.target && (state == ST_OFFER);
  assign ack_o    = !kind_q.target && (state == ST_CLOSE);
  assign drive_en = kind_q.send && on_bus;
  assign cap_en   = !kind_q.send && on_bus && strobe_hi;

  // R12: a low enable always leaves the engine idle one cycle later.
  assert_abort_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |=> state == ST_IDLE);

  // R2 / R4: ACK only ever rises in answer to a REQ seen the cycle before.
  assert_ack_follows_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> $past(req_i));

  // R3 / R5: REQ is withdrawn during a transfer only after ACK was seen.
  assert_req_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(req_o) && state != ST_IDLE) |-> $past(ack_i));

endmodule

// File: rtl/sdh_datapath.sv
module sdh_datapath #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_tx,
  input  logic [DATA_W-1:0] tx_in,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] db_in,
  output logic [DATA_W-1:0] tx_q,
  output logic [DATA_W-1:0] rx_q
);

  // tx_q holds the outgoing byte for its whole handshake; rx_q tracks the
  // bus while the partner strobe is high, so it freezes on the falling edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load_tx) tx_q <= tx_in;
      if (cap_en)  rx_q <= db_in;
    end
  end

endmodule

// File: rtl/sdh_status.sv
module sdh_status (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_start,
  input  logic evt_done,
  input  logic evt_last_sent,
  input  logic evt_mismatch,
  input  logic eop_irq_en,
  output logic end_flag,
  output logic sent_flag,
  output logic phase_flag,
  output logic irq
);

  always_ff @(posedge clk) begin
    if (!rst_n || evt_start) begin
      end_flag   <= 1'b0;
      sent_flag  <= 1'b0;
      phase_flag <= 1'b0;
      irq        <= 1'b0;
    end else begin
      if (evt_done)      end_flag  <= 1'b1;
      if (evt_last_sent) sent_flag <= 1'b1;
      if (evt_mismatch) begin
        phase_flag <= 1'b1;
        irq        <= 1'b1;
      end
      if (evt_done && eop_irq_en) irq <= 1'b1;
    end
  end

  // R1: an accepted start leaves every flag clear.
  assert_flags_cleared_R1: assert property (@(posedge clk) disable iff (!rst_n)
    evt_start |=> !end_flag && !phase_flag && !irq && !sent_flag);

  // R10 / R11: an interrupt appears only with a cause that permits it.
  assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (phase_flag || (end_flag && $past(eop_irq_en))));

endmodule

// File: rtl/scsi_dma_engine.sv
module scsi_dma_engine
  import sdh_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 8,
  parameter int PHASE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_wr,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic               dma_en,
  input  logic               blk_mode,
  input  logic               tgt_mode,
  input  logic               eop_irq_en,
  input  logic [PHASE_W-1:0] exp_phase,
  input  logic [PHASE_W-1:0] bus_phase,
  input  logic               snd_valid,
  output logic               snd_ready,
  input  logic [DATA_W-1:0]  snd_data,
  input  logic               host_last,
  output logic               rcv_valid,
  input  logic               rcv_ready,
  output logic [DATA_W-1:0]  rcv_data,
  output logic               dreq,
  input  logic               scsi_req_i,
  input  logic               scsi_ack_i,
  output logic               scsi_req_o,
  output logic               scsi_ack_o,
  input  logic [DATA_W-1:0]  scsi_db_i,
  output logic [DATA_W-1:0]  scsi_db_o,
  output logic               scsi_db_oe,
  output logic               xfer_busy,
  output logic               dma_end,
  output logic               tx_last_done,
  output logic               phase_fault,
  output logic               irq
);

  sdh_state_e state;
  sdh_kind_t  start_kind;
  logic       start_go;
  logic       snd_beat, rcv_beat, cap_en;
  logic       evt_start, evt_done, evt_last_sent, evt_mismatch;

  sdh_launch #(.ADDR_W(ADDR_W)) u_launch (
    .cmd_wr   (cmd_wr),
    .cmd_addr (cmd_addr),
    .tgt_mode (tgt_mode),
    .go       (start_go),
    .kind     (start_kind)
  );

  sdh_sequencer u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .go            (start_go),
    .kind          (start_kind),
    .dma_en        (dma_en),
    .phase_match   (bus_phase == exp_phase),
    .req_i         (scsi_req_i),
    .ack_i         (scsi_ack_i),
    .snd_beat      (snd_beat),
    .rcv_beat      (rcv_beat),
    .host_last     (host_last),
    .state         (state),
    .req_o         (scsi_req_o),
    .ack_o         (scsi_ack_o),
    .drive_en      (scsi_db_oe),
    .cap_en        (cap_en),
    .evt_start     (evt_start),
    .evt_done      (evt_done),
    .evt_last_sent (evt_last_sent),
    .evt_mismatch  (evt_mismatch)
  );

  sdh_datapath #(.DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_tx (snd_beat),
    .tx_in   (snd_data),
    .cap_en  (cap_en),
    .db_in   (scsi_db_i),
    .tx_q    (scsi_db_o),
    .rx_q    (rcv_data)
  );

  sdh_status u_stat (
    .clk           (clk),
    .rst_n         (rst_n),
    .evt_start     (evt_start),
    .evt_done      (evt_done),
    .evt_last_sent (evt_last_sent),
    .evt_mismatch  (evt_mismatch),
    .eop_irq_en    (eop_irq_en),
    .end_flag      (dma_end),
    .sent_flag     (tx_last_done),
    .phase_flag    (phase_fault),
    .irq           (irq)
  );

  assign snd_ready = (state == ST_FETCH);
  assign rcv_valid = (state == ST_DELIVER);
  assign xfer_busy = (state != ST_IDLE);
  assign snd_beat  = snd_valid && snd_ready;
  assign rcv_beat  = rcv_valid && rcv_ready;
  assign dreq      = blk_mode ? xfer_busy : (snd_ready || rcv_valid);

  // R13: a driven byte does not change while the drivers stay on.
  assert_data_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (scsi_db_oe && $past(scsi_db_oe)) |-> $stable(scsi_db_o));

  // R13: an offered byte stays put until the host takes it.
  assert_rcv_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (rcv_valid && !rcv_ready) |=> (!rcv_valid || $stable(rcv_data)));

  // R6 / R7: any pending host beat is always announced on dreq.
  assert_dreq_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_ready || rcv_valid) |-> dreq);

endmodule

// File: tb/tb_scsi_dma_engine.sv
module tb_scsi_dma_engine;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_wr;
  logic [2:0] cmd_addr;
  logic       dma_en, blk_mode, tgt_mode, eop_irq_en;
  logic [2:0] exp_phase, bus_phase;
  logic       snd_valid, snd_ready;
  logic [7:0] snd_data;
  logic       host_last;
  logic       rcv_valid, rcv_ready;
  logic [7:0] rcv_data;
  logic       dreq;
  logic       scsi_req_i, scsi_ack_i, scsi_req_o, scsi_ack_o;
  logic [7:0] scsi_db_i, scsi_db_o;
  logic       scsi_db_oe, xfer_busy, dma_end, tx_last_done, phase_fault, irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  scsi_dma_engine dut (.*);

  // {kind[15:14], blk[13], irq_en[12], count[11:8], first byte[7:0]}
  // kind: 0 initiator send, 1 target send, 2 initiator receive, 3 target receive
  localparam logic [15:0] VECS [8] = '{
    {2'd0, 1'b0, 1'b1, 4'd1, 8'hA5},
    {2'd1, 1'b0, 1'b0, 4'd1, 8'h3C},
    {2'd2, 1'b0, 1'b1, 4'd1, 8'hC3},
    {2'd3, 1'b0, 1'b0, 4'd1, 8'h5A},
    {2'd0, 1'b1, 1'b0, 4'd3, 8'h10},
    {2'd1, 1'b1, 1'b1, 4'd2, 8'h81},
    {2'd2, 1'b1, 1'b0, 4'd3, 8'h7E},
    {2'd3, 1'b1, 1'b1, 4'd2, 8'hF0}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic start(input logic [2:0] a);
    cmd_wr = 1'b1; cmd_addr = a;
    tick();
    cmd_wr = 1'b0; cmd_addr = 3'd0;
  endtask

  task automatic abort();
    dma_en = 1'b0; tick(); dma_en = 1'b1;
    scsi_req_i = 1'b0; scsi_ack_i = 1'b0;
  endtask

  task automatic run_xfer(input logic [15:0] v);
    int   kind;
    logic blk, ien;
    int   cnt;
    logic [7:0] b;
    kind = int'(v[15:14]); blk = v[13]; ien = v[12]; cnt = int'(v[11:8]);
    blk_mode = blk; eop_irq_en = ien; tgt_mode = (kind == 1);
    start(kind < 2 ? 3'd5 : (kind == 3 ? 3'd6 : 3'd7));
    check(xfer_busy == 1'b1, "R1 start accepted", int'(xfer_busy), 1);
    check(!dma_end && !phase_fault && !irq, "R1 flags cleared",
          int'({dma_end, phase_fault, irq}), 0);
    for (int i = 0; i < cnt; i++) begin
      b = v[7:0] + 8'(i * 37);
      if (kind < 2) begin
        check(snd_ready && dreq, "R6 dreq for send byte", int'({snd_ready, dreq}), 3);
        snd_valid = 1'b1; snd_data = b; host_last = (i == cnt - 1);
        tick();
        snd_valid = 1'b0; host_last = 1'b0; snd_data = 8'h00;
        if (blk) check(dreq == 1'b1, "R7 dreq held in block mode", int'(dreq), 1);
        else     check(dreq == 1'b0, "R6 dreq drops after beat", int'(dreq), 0);
        check(scsi_db_oe && scsi_db_o == b, "R13 byte driven", int'(scsi_db_o), int'(b));
        if (kind == 0) begin
          check(scsi_ack_o == 1'b0, "R2 no ack before req", int'(scsi_ack_o), 0);
          scsi_req_i = 1'b1; tick();
          check(scsi_ack_o == 1'b1, "R2 ack after req", int'(scsi_ack_o), 1);
          scsi_req_i = 1'b0; tick();
          check(scsi_ack_o == 1'b0, "R2 ack released", int'(scsi_ack_o), 0);
        end else begin
          check(scsi_req_o == 1'b1, "R3 req raised", int'(scsi_req_o), 1);
          scsi_ack_i = 1'b1; tick();
          check(scsi_req_o == 1'b0 && scsi_db_oe, "R3 req released, data held",
                int'({scsi_req_o, scsi_db_oe}), 1);
          scsi_ack_i = 1'b0; tick();
        end
      end else begin
        if (kind == 2) begin
          check(scsi_ack_o == 1'b0, "R4 no ack before req", int'(scsi_ack_o), 0);
          scsi_db_i = b ^ 8'h5A; scsi_req_i = 1'b1; tick();
          check(scsi_ack_o == 1'b1, "R4 ack after req", int'(scsi_ack_o), 1);
          scsi_db_i = b; tick();
          scsi_db_i = ~b; scsi_req_i = 1'b0; tick();
          check(scsi_ack_o == 1'b0, "R4 ack released", int'(scsi_ack_o), 0);
          check(rcv_valid && rcv_data == b, "R4 falling-edge byte", int'(rcv_data), int'(b));
        end else begin
          check(scsi_req_o == 1'b1, "R5 req raised", int'(scsi_req_o), 1);
          scsi_db_i = b ^ 8'h5A; scsi_ack_i = 1'b1; tick();
          check(scsi_req_o == 1'b0, "R5 req released", int'(scsi_req_o), 0);
          scsi_db_i = b; tick();
          scsi_db_i = ~b; scsi_ack_i = 1'b0; tick();
          check(rcv_valid && rcv_data == b, "R5 falling-edge byte", int'(rcv_data), int'(b));
        end
        check(dreq == 1'b1, "R6 dreq for received byte", int'(dreq), 1);
        rcv_ready = 1'b1; host_last = (i == cnt - 1);
        tick();
        rcv_ready = 1'b0; host_last = 1'b0;
        if (i != cnt - 1) begin
          if (blk) check(dreq == 1'b1, "R7 dreq held in block mode", int'(dreq), 1);
          else     check(dreq == 1'b0, "R6 dreq drops after beat", int'(dreq), 0);
        end
      end
    end
    check(!xfer_busy && dma_end && !dreq, "R8 end of transfer",
          int'({xfer_busy, dma_end, dreq}), 2);
    check(tx_last_done == (kind < 2), "R9 last byte sent flag",
          int'(tx_last_done), int'(kind < 2));
    check(irq == ien, "R10 end interrupt gating", int'(irq), int'(ien));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got %0h expected %0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] c;
    rst_n = 1'b0; cmd_wr = 1'b0; cmd_addr = 3'd0; dma_en = 1'b1; blk_mode = 1'b0;
    tgt_mode = 1'b0; eop_irq_en = 1'b0; exp_phase = 3'd0; bus_phase = 3'd0;
    snd_valid = 1'b0; snd_data = 8'h00; host_last = 1'b0; rcv_ready = 1'b0;
    scsi_req_i = 1'b0; scsi_ack_i = 1'b0; scsi_db_i = 8'h00;
    repeat (3) tick();
    rst_n = 1'b1; tick();
    check({snd_ready, rcv_valid, rcv_data, dreq, scsi_req_o, scsi_ack_o, scsi_db_o,
           scsi_db_oe, xfer_busy, dma_end, tx_last_done, phase_fault, irq} == '0,
          "R14 reset outputs", int'(xfer_busy), 0);

    for (int k = 0; k < 8; k++) run_xfer(VECS[k]);

    // R1: non-start addresses and disabled starts are ignored
    for (int a = 0; a < 5; a++) begin
      start(3'(a));
      check(xfer_busy == 1'b0, "R1 ignored address", int'(xfer_busy), 0);
    end
    dma_en = 1'b0; start(3'd5); dma_en = 1'b1;
    check(xfer_busy == 1'b0, "R1 start while disabled", int'(xfer_busy), 0);

    // R1: start while busy ignored (receive stays a receive)
    tgt_mode = 1'b0; start(3'd7); start(3'd5);
    check(xfer_busy && !snd_ready, "R1 start while busy", int'(snd_ready), 0);
    scsi_req_i = 1'b1; tick();
    check(scsi_ack_o == 1'b1, "R1 original transfer kept", int'(scsi_ack_o), 1);
    abort();

    // R12: abort while a byte is driven
    start(3'd5);
    snd_valid = 1'b1; snd_data = 8'h66; tick(); snd_valid = 1'b0;
    check(scsi_db_oe == 1'b1, "R12 driving before abort", int'(scsi_db_oe), 1);
    dma_en = 1'b0; tick();
    check(!xfer_busy && !scsi_db_oe && !scsi_ack_o && !dma_end && !irq,
          "R12 abort to idle", int'({xfer_busy, scsi_db_oe, dma_end, irq}), 0);
    dma_en = 1'b1;

    // R12: abort a target receive releases REQ
    start(3'd6);
    check(scsi_req_o == 1'b1, "R12 req before abort", int'(scsi_req_o), 1);
    dma_en = 1'b0; tick(); dma_en = 1'b1;
    check(scsi_req_o == 1'b0 && !xfer_busy, "R12 req released", int'(scsi_req_o), 0);

    // R13: stalled send stream leaves the bus alone
    start(3'd5);
    scsi_req_i = 1'b1;
    repeat (3) tick();
    check(snd_ready && !scsi_ack_o && !scsi_db_oe, "R13 send stall",
          int'({snd_ready, scsi_ack_o, scsi_db_oe}), 4);
    abort();

    // R13: stalled receive holds data and withholds ACK
    start(3'd7);
    scsi_db_i = 8'h9D; scsi_req_i = 1'b1; tick();
    scsi_req_i = 1'b0; scsi_db_i = 8'h00; tick();
    scsi_req_i = 1'b1; c = 8'h42; scsi_db_i = c;
    repeat (3) tick();
    check(rcv_valid && rcv_data == 8'h9D && !scsi_ack_o, "R13 receive stall",
          int'(rcv_data), 'h9D);
    rcv_ready = 1'b1; tick(); rcv_ready = 1'b0;
    check(scsi_ack_o == 1'b0, "R4 next req seen after take", int'(scsi_ack_o), 0);
    tick();
    check(scsi_ack_o == 1'b1, "R4 next req acknowledged", int'(scsi_ack_o), 1);
    scsi_req_i = 1'b0; scsi_db_i = 8'h00; tick();
    check(rcv_valid && rcv_data == c, "R4 second byte", int'(rcv_data), int'(c));
    rcv_ready = 1'b1; host_last = 1'b1; tick(); rcv_ready = 1'b0; host_last = 1'b0;
    check(!xfer_busy && dma_end && !tx_last_done, "R9 receive end no sent flag",
          int'({xfer_busy, dma_end, tx_last_done}), 2);

    // R11: phase mismatch stops an initiator transfer
    exp_phase = 3'b001; bus_phase = 3'b001; tgt_mode = 1'b0;
    start(3'd7);
    check(xfer_busy == 1'b1, "R11 running with matching phase", int'(xfer_busy), 1);
    bus_phase = 3'b011; tick();
    check(!xfer_busy && phase_fault && irq && !dma_end, "R11 mismatch stop",
          int'({xfer_busy, phase_fault, irq, dma_end}), 6);

    // R11: target role ignores the phase lines
    tgt_mode = 1'b1; start(3'd5);
    repeat (3) tick();
    check(xfer_busy && !phase_fault, "R11 target ignores phase",
          int'({xfer_busy, phase_fault}), 2);
    abort();
    exp_phase = 3'd0; bus_phase = 3'd0; tgt_mode = 1'b0;

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule